// File: doc/BRIEF.md
# Special-Register Move Execution Stage

This block is the execute step for special-purpose-register moves in a 64-bit core. Each cycle it receives one decoded operation: a micro-op code, the raw 32-bit instruction word, a routing tag, a source operand, the current value of the one fast-path register the issue logic has selected, and the fixed-point exception flags (SO, OV/OV32, CA/CA32). It returns a result for the general register file, a write for the fast-path register file, and separate writes for the three exception-flag groups. Each write carries its own valid bit. It has no state, so every output is a function of the inputs presented in the same cycle.

The special register is picked by a 10-bit number. That number is held in the instruction with its two 5-bit halves swapped. The fast-path group is the count, link, target-address and the two save/restore registers. The exception register is not stored as a word here. A move-to splits it into flag fields, and a move-from rebuilds it from those fields. Bit positions use big-endian numbering, where architectural bit n is little-endian index 63−n. Operation code, instruction word and tag pass through unchanged so that later stages can steer the results.

Top module: `spr_move_stage`

## Requirements
- R1: `op_type_o`, `insn_o` and `tag_o` always equal `op_type_i`, `insn_i` and `tag_i`.
- R2: The SPR number is `{insn_i[15:11], insn_i[20:16]}`. A move-to (`op_type_i` = 50) whose number is 9, 8, 815, 26 or 27 sets `fast_wr_vld_o` and drives `fast_wr_o` with `opnd_i`.
- R3: A move-to on a fast-path number leaves `so_wr_vld_o`, `ov_wr_vld_o` and `ca_wr_vld_o` low.
- R4: A move-to on number 1 sets all three flag write-valids. It drives `so_wr_o` = `opnd_i[31]` (architectural bit 32), `ov_wr_o` = {`opnd_i[19]`, `opnd_i[30]`} ({OV32 at bit 44, OV at bit 33}) and `ca_wr_o` = {`opnd_i[18]`, `opnd_i[29]`} ({CA32 at bit 45, CA at bit 34}).
- R5: A move-to on number 1 leaves `fast_wr_vld_o` low.
- R6: Every move-from (`op_type_i` = 51) sets `res_vld_o` and leaves all four write-valids low. Any other op code leaves `res_vld_o` low.
- R7: A move-from on a fast-path number returns `fast_i` unchanged on `res_o`.
- R8: A move-from on number 1 returns `xer_so_i` at `res_o[31]`, `xer_ov_i[0]` at `[30]`, `xer_ca_i[0]` at `[29]`, `xer_ov_i[1]` at `[19]` and `xer_ca_i[1]` at `[18]`. Every other bit is zero.
- R9: A number outside {1, 8, 9, 26, 27, 815} sets no write-valid. This includes a number whose halves were not swapped. A move-from on such a number returns zero with `res_vld_o` set.
- R10: An op code other than 50 or 51 sets no valid output.
- R11: Every data output whose valid bit is low reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_type_i | input | 7 | Micro-op code (50 move-to, 51 move-from) |
| insn_i | input | 32 | Raw instruction word |
| tag_i | input | 2 | Routing tag |
| opnd_i | input | 64 | Source operand for move-to |
| fast_i | input | 64 | Current fast-path register value |
| xer_so_i | input | 1 | Current SO flag |
| xer_ov_i | input | 2 | Current {OV32, OV} |
| xer_ca_i | input | 2 | Current {CA32, CA} |
| op_type_o | output | 7 | Passed-through micro-op code |
| insn_o | output | 32 | Passed-through instruction word |
| tag_o | output | 2 | Passed-through routing tag |
| res_o | output | 64 | Move-from result |
| res_vld_o | output | 1 | Result valid |
| fast_wr_o | output | 64 | Fast-path register write data |
| fast_wr_vld_o | output | 1 | Fast-path write valid |
| so_wr_o | output | 1 | SO write data |
| so_wr_vld_o | output | 1 | SO write valid |
| ov_wr_o | output | 2 | {OV32, OV} write data |
| ov_wr_vld_o | output | 1 | OV group write valid |
| ca_wr_o | output | 2 | {CA32, CA} write data |
| ca_wr_vld_o | output | 1 | CA group write valid |

## Verification
The bench uses the default parameters: a 64-bit word, 7-bit op codes with move-to 50 and move-from 51, and a 2-bit tag. The 64-bit width fixes every big-endian flag position at a definite little-endian index. The bench drives all six defined SPR numbers, four unrecognised ones (one of them an unswapped encoding of the count register), and three op codes, each with patterned and random operands and flag values. This reaches every scatter and gather bit, the exclusion between the fast-path and flag writes, and the zeroing of idle data outputs.

// File: rtl/spr_move_pkg.sv
package spr_move_pkg;

  typedef enum logic [1:0] {
    SPR_NONE = 2'd0,
    SPR_FAST = 2'd1,
    SPR_XER  = 2'd2
  } spr_class_e;

  localparam int SPRN_W   = 10;
  localparam int HALF_W   = SPRN_W / 2;

  localparam logic [SPRN_W-1:0] SPRN_XER  = 10'd1;
  localparam logic [SPRN_W-1:0] SPRN_LR   = 10'd8;
  localparam logic [SPRN_W-1:0] SPRN_CTR  = 10'd9;
  localparam logic [SPRN_W-1:0] SPRN_SRR0 = 10'd26;
  localparam logic [SPRN_W-1:0] SPRN_SRR1 = 10'd27;
  localparam logic [SPRN_W-1:0] SPRN_TAR  = 10'd815;

  // architectural (big-endian) flag positions
  localparam int ABIT_SO   = 32;
  localparam int ABIT_OV   = 33;
  localparam int ABIT_CA   = 34;
  localparam int ABIT_OV32 = 44;
  localparam int ABIT_CA32 = 45;

  // big-endian bit n of an xlen-bit word -> little-endian index
  function automatic int be_idx(input int xlen, input int n);
    return xlen - 1 - n;
  endfunction

  // instruction field holds the two halves in reverse order
  function automatic logic [SPRN_W-1:0] unswap_sprn(input logic [SPRN_W-1:0] raw);
    return {raw[HALF_W-1:0], raw[SPRN_W-1:HALF_W]};
  endfunction

  function automatic spr_class_e classify_sprn(input logic [SPRN_W-1:0] n);
    spr_class_e c;
    unique case (n)
      SPRN_XER:                                       c = SPR_XER;
      SPRN_LR, SPRN_CTR, SPRN_SRR0, SPRN_SRR1, SPRN_TAR: c = SPR_FAST;
      default:                                        c = SPR_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/spr_num_decode.sv
module spr_num_decode
  import spr_move_pkg::*;
#(
  parameter int INSN_W    = 32,
  parameter int FIELD_LSB = 11
) (
  input  logic [INSN_W-1:0] insn,
  output logic [SPRN_W-1:0] sprn,
  output spr_class_e        cls
);
  localparam int FIELD_MSB = FIELD_LSB + SPRN_W - 1;

  logic [SPRN_W-1:0] raw_field;

  assign raw_field = insn[FIELD_MSB:FIELD_LSB];
  assign sprn      = unswap_sprn(raw_field);
  assign cls       = classify_sprn(sprn);
endmodule

// File: rtl/spr_write_path.sv
module spr_write_path
  import spr_move_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            mt_en,
  input  spr_class_e      cls,
  input  logic [XLEN-1:0] opnd,
  output logic [XLEN-1:0] fast_data,
  output logic            fast_vld,
  output logic            so_data,
  output logic            so_vld,
  output logic [1:0]      ov_data,
  output logic            ov_vld,
  output logic [1:0]      ca_data,
  output logic            ca_vld
);
  localparam int I_SO   = be_idx(XLEN, ABIT_SO);
  localparam int I_OV   = be_idx(XLEN, ABIT_OV);
  localparam int I_CA   = be_idx(XLEN, ABIT_CA);
  localparam int I_OV32 = be_idx(XLEN, ABIT_OV32);
  localparam int I_CA32 = be_idx(XLEN, ABIT_CA32);

  logic to_fast, to_flags;

  assign to_fast  = mt_en && (cls == SPR_FAST);
  assign to_flags = mt_en && (cls == SPR_XER);

  always_comb begin
    fast_data = '0;
    fast_vld  = 1'b0;
    so_data   = 1'b0;
    so_vld    = 1'b0;
    ov_data   = 2'b00;
    ov_vld    = 1'b0;
    ca_data   = 2'b00;
    ca_vld    = 1'b0;
    if (to_fast) begin
      fast_data = opnd;
      fast_vld  = 1'b1;
    end
    if (to_flags) begin
      so_data = opnd[I_SO];
      ov_data = {opnd[I_OV32], opnd[I_OV]};
      ca_data = {opnd[I_CA32], opnd[I_CA]};
      so_vld  = 1'b1;
      ov_vld  = 1'b1;
      ca_vld  = 1'b1;
    end
  end
endmodule

// File: rtl/spr_read_path.sv
module spr_read_path
  import spr_move_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            mf_en,
  input  spr_class_e      cls,
  input  logic [XLEN-1:0] fast_val,
  input  logic            so,
  input  logic [1:0]      ov,
  input  logic [1:0]      ca,
  output logic [XLEN-1:0] res,
  output logic            res_vld
);
  localparam int NFLAG = 5;

  logic [XLEN-1:0] xer_image;
  logic [NFLAG-1:0] flag_val;

  // flag order: SO, OV, CA, OV32, CA32
  assign flag_val = {ca[1], ov[1], ca[0], ov[0], so};

  function automatic int flag_pos(input int k);
    int p;
    case (k)
      0:       p = ABIT_SO;
      1:       p = ABIT_OV;
      2:       p = ABIT_CA;
      3:       p = ABIT_OV32;
      default: p = ABIT_CA32;
    endcase
    return be_idx(XLEN, p);
  endfunction

  always_comb begin
    xer_image = '0;
    for (int k = 0; k < NFLAG; k++) begin
      xer_image[flag_pos(k)] = flag_val[k];
    end
  end

  always_comb begin
    res     = '0;
    res_vld = mf_en;
    if (mf_en) begin
      unique case (cls)
        SPR_FAST: res = fast_val;
        SPR_XER:  res = xer_image;
        default:  res = '0;
      endcase
    end
  end
endmodule

// File: rtl/spr_move_stage.sv
module spr_move_stage
  import spr_move_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter int              INSN_W    = 32,
  parameter int              OPC_W     = 7,
  parameter int              TAG_W     = 2,
  parameter logic [OPC_W-1:0] OPC_MT   = 7'd50,
  parameter logic [OPC_W-1:0] OPC_MF   = 7'd51
) (
  input  logic [OPC_W-1:0]  op_type_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [XLEN-1:0]   opnd_i,
  input  logic [XLEN-1:0]   fast_i,
  input  logic              xer_so_i,
  input  logic [1:0]        xer_ov_i,
  input  logic [1:0]        xer_ca_i,
  output logic [OPC_W-1:0]  op_type_o,
  output logic [INSN_W-1:0] insn_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [XLEN-1:0]   res_o,
  output logic              res_vld_o,
  output logic [XLEN-1:0]   fast_wr_o,
  output logic              fast_wr_vld_o,
  output logic              so_wr_o,
  output logic              so_wr_vld_o,
  output logic [1:0]        ov_wr_o,
  output logic              ov_wr_vld_o,
  output logic [1:0]        ca_wr_o,
  output logic              ca_wr_vld_o
);
  // named internal events for the checker
  logic              mt_fire;
  logic              mf_fire;
  logic [SPRN_W-1:0] spr_num;
  spr_class_e        spr_cls;

  assign mt_fire = (op_type_i == OPC_MT);
  assign mf_fire = (op_type_i == OPC_MF);

  assign op_type_o = op_type_i;
  assign insn_o    = insn_i;
  assign tag_o     = tag_i;

  spr_num_decode #(.INSN_W(INSN_W), .FIELD_LSB(11)) u_dec (
    .insn (insn_i),
    .sprn (spr_num),
    .cls  (spr_cls)
  );

  spr_write_path #(.XLEN(XLEN)) u_wr (
    .mt_en     (mt_fire),
    .cls       (spr_cls),
    .opnd      (opnd_i),
    .fast_data (fast_wr_o),
    .fast_vld  (fast_wr_vld_o),
    .so_data   (so_wr_o),
    .so_vld    (so_wr_vld_o),
    .ov_data   (ov_wr_o),
    .ov_vld    (ov_wr_vld_o),
    .ca_data   (ca_wr_o),
    .ca_vld    (ca_wr_vld_o)
  );

  spr_read_path #(.XLEN(XLEN)) u_rd (
    .mf_en    (mf_fire),
    .cls      (spr_cls),
    .fast_val (fast_i),
    .so       (xer_so_i),
    .ov       (xer_ov_i),
    .ca       (xer_ca_i),
    .res      (res_o),
    .res_vld  (res_vld_o)
  );
endmodule

// File: rtl/spr_move_checker.sv
module spr_move_checker
  import spr_move_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            mt_fire,
  input logic            mf_fire,
  input spr_class_e      spr_cls,
  input logic [XLEN-1:0] opnd_i,
  input logic [XLEN-1:0] fast_i,
  input logic [XLEN-1:0] res_o,
  input logic            res_vld_o,
  input logic [XLEN-1:0] fast_wr_o,
  input logic            fast_wr_vld_o,
  input logic            so_wr_vld_o,
  input logic            ov_wr_vld_o,
  input logic            ca_wr_vld_o
);
  logic any_flag_vld;
  assign any_flag_vld = so_wr_vld_o | ov_wr_vld_o | ca_wr_vld_o;

  always_comb begin
    // R2: fast move-to carries the operand
    p_mt_fast_data_r2: assert (!(mt_fire && spr_cls == SPR_FAST) ||
                               (fast_wr_vld_o && fast_wr_o == opnd_i));
    // R3: fast and flag writes never together
    p_fast_excl_flags_r3: assert (!(fast_wr_vld_o && any_flag_vld));
    // R4: flag group valids rise together
    p_flag_vld_group_r4: assert (so_wr_vld_o == ov_wr_vld_o && ov_wr_vld_o == ca_wr_vld_o);
    // R5: XER move-to never writes the fast path
    p_mt_xer_no_fast_r5: assert (!(mt_fire && spr_cls == SPR_XER) || !fast_wr_vld_o);
    // R6: a result only on move-from, and then no writes
    p_mf_result_r6: assert (res_vld_o == mf_fire);
    p_mf_no_write_r6: assert (!res_vld_o || (!fast_wr_vld_o && !any_flag_vld));
    // R7: fast move-from returns input
    p_mf_fast_r7: assert (!(mf_fire && spr_cls == SPR_FAST) || res_o == fast_i);
    // R9: unrecognised number writes nothing
    p_none_no_write_r9: assert (spr_cls != SPR_NONE || (!fast_wr_vld_o && !any_flag_vld));
    // R11: idle data outputs are zero
    p_idle_zero_r11: assert ((res_vld_o || res_o == '0) && (fast_wr_vld_o || fast_wr_o == '0));
  end
endmodule

bind spr_move_stage spr_move_checker #(.XLEN(XLEN)) u_chk (
  .mt_fire       (mt_fire),
  .mf_fire       (mf_fire),
  .spr_cls       (spr_cls),
  .opnd_i        (opnd_i),
  .fast_i        (fast_i),
  .res_o         (res_o),
  .res_vld_o     (res_vld_o),
  .fast_wr_o     (fast_wr_o),
  .fast_wr_vld_o (fast_wr_vld_o),
  .so_wr_vld_o   (so_wr_vld_o),
  .ov_wr_vld_o   (ov_wr_vld_o),
  .ca_wr_vld_o   (ca_wr_vld_o)
);

// File: tb/spr_move_stage_bench.sv
module spr_move_stage_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  logic [6:0]  op_type_i, op_type_o;
  logic [31:0] insn_i, insn_o;
  logic [1:0]  tag_i, tag_o;
  logic [63:0] opnd_i, fast_i, res_o, fast_wr_o;
  logic        xer_so_i, res_vld_o, fast_wr_vld_o, so_wr_o, so_wr_vld_o;
  logic        ov_wr_vld_o, ca_wr_vld_o;
  logic [1:0]  xer_ov_i, xer_ca_i, ov_wr_o, ca_wr_o;

  spr_move_stage u_spr_move_stage (.*);

  typedef struct {
    logic [6:0]  op;
    logic [31:0] insn;
    logic [1:0]  tag;
    logic [63:0] res;
    logic        res_v;
    logic [63:0] fast;
    logic        fast_v;
    logic        so;
    logic        so_v;
    logic [1:0]  ov;
    logic        ov_v;
    logic [1:0]  ca;
    logic        ca_v;
  } exp_t;

  exp_t scb[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   driving_done = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // independent model, from the requirements
  function automatic exp_t model(input logic [6:0] op, input logic [31:0] insn, input logic [1:0] tag,
                                 input logic [63:0] a, input logic [63:0] f,
                                 input logic so, input logic [1:0] ov, input logic [1:0] ca);
    exp_t e;
    int   n;
    bit   is_fast, is_xer;
    n = {insn[15:11], insn[20:16]};
    is_xer  = (n == 1);
    is_fast = (n == 8 || n == 9 || n == 26 || n == 27 || n == 815);
    e.op = op; e.insn = insn; e.tag = tag;
    e.res = '0; e.res_v = 0; e.fast = '0; e.fast_v = 0;
    e.so = 0; e.so_v = 0; e.ov = 0; e.ov_v = 0; e.ca = 0; e.ca_v = 0;
    if (op == 7'd50) begin
      if (is_fast) begin e.fast = a; e.fast_v = 1; end
      if (is_xer) begin
        e.so = a[63-32]; e.ov = {a[63-44], a[63-33]}; e.ca = {a[63-45], a[63-34]};
        e.so_v = 1; e.ov_v = 1; e.ca_v = 1;
      end
    end else if (op == 7'd51) begin
      e.res_v = 1;
      if (is_fast) e.res = f;
      if (is_xer) begin
        e.res[63-32] = so; e.res[63-33] = ov[0]; e.res[63-34] = ca[0];
        e.res[63-44] = ov[1]; e.res[63-45] = ca[1];
      end
    end
    return e;
  endfunction

  function automatic logic [31:0] enc(input int n, input logic [31:0] filler);
    logic [31:0] w;
    logic [9:0]  nn;
    nn = n[9:0];
    w = filler;
    w[20:16] = nn[4:0];
    w[15:11] = nn[9:5];
    return w;
  endfunction

  task automatic drive(input logic [6:0] op, input logic [31:0] insn, input logic [1:0] tag,
                       input logic [63:0] a, input logic [63:0] f,
                       input logic so, input logic [1:0] ov, input logic [1:0] ca);
    @(posedge clk);
    #1;
    op_type_i = op; insn_i = insn; tag_i = tag; opnd_i = a; fast_i = f;
    xer_so_i = so; xer_ov_i = ov; xer_ca_i = ca;
    scb.push_back(model(op, insn, tag, a, f, so, ov, ca));
  endtask

  // monitor: settled combinational outputs at the falling edge
  always @(negedge clk) begin
    if (scb.size() > 0) begin
      exp_t e;
      e = scb.pop_front();
      chk("R1", "op",   {57'd0, op_type_o}, {57'd0, e.op});
      chk("R1", "insn", {32'd0, insn_o}, {32'd0, e.insn});
      chk("R1", "tag",  {62'd0, tag_o}, {62'd0, e.tag});
      chk("R6", "res_vld", {63'd0, res_vld_o}, {63'd0, e.res_v});
      chk("R7_R8_R9", "res", res_o, e.res);
      chk("R2_R5", "fast_vld", {63'd0, fast_wr_vld_o}, {63'd0, e.fast_v});
      chk("R2_R11", "fast", fast_wr_o, e.fast);
      chk("R3_R4_R10", "flag_vld", {61'd0, so_wr_vld_o, ov_wr_vld_o, ca_wr_vld_o},
          {61'd0, e.so_v, e.ov_v, e.ca_v});
      chk("R4_R11", "flags", {59'd0, so_wr_o, ov_wr_o, ca_wr_o}, {59'd0, e.so, e.ov, e.ca});
    end
  end

  initial begin
    int watchdog = 0;
    forever begin
      @(posedge clk);
      watchdog++;
      if (watchdog > 50000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  int sprs[10] = '{1, 8, 9, 26, 27, 815, 2, 288, 0, 1023};
  logic [6:0] ops[3] = '{7'd50, 7'd51, 7'd0};

  initial begin
    op_type_i = '0; insn_i = '0; tag_i = '0; opnd_i = '0; fast_i = '0;
    xer_so_i = 0; xer_ov_i = '0; xer_ca_i = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-state check (R10): idle op code, all valids low
    drive(7'd0, 32'd0, 2'd0, '0, '0, 1'b0, 2'b00, 2'b00);
    // R9: unswapped encoding of the count register is not recognised
    drive(7'd50, {11'd0, 10'd9, 11'd0}, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, '0, 1'b1, 2'b11, 2'b11);
    drive(7'd51, {11'd0, 10'd9, 11'd0}, 2'd2, '0, 64'h1234_5678_9ABC_DEF0, 1'b1, 2'b11, 2'b11);
    // R4/R8: isolated flag bits
    for (int b = 0; b < 5; b++) begin
      logic [63:0] a;
      int pos [5] = '{32, 33, 34, 44, 45};
      a = '0; a[63 - pos[b]] = 1'b1;
      drive(7'd50, enc(1, 32'h7C00_03A6), 2'd3, a, '0, 1'b0, 2'b00, 2'b00);
      drive(7'd51, enc(1, 32'h7C00_02A6), 2'd0, '0, '0, b == 0, {b == 3, b == 1}, {b == 4, b == 2});
    end
    for (int s = 0; s < 10; s++) begin
      for (int o = 0; o < 3; o++) begin
        for (int p = 0; p < 4; p++) begin
          logic [63:0] a, f;
          logic [31:0] fl;
          case (p)
            0: begin a = 64'hFFFF_FFFF_FFFF_FFFF; f = 64'h0; end
            1: begin a = 64'hAAAA_AAAA_AAAA_AAAA; f = 64'h5555_5555_5555_5555; end
            2: begin a = 64'h0; f = 64'hFFFF_FFFF_FFFF_FFFF; end
            default: begin a = {$urandom, $urandom}; f = {$urandom, $urandom}; end
          endcase
          fl = $urandom;
          drive(ops[o], enc(sprs[s], fl), 2'(p), a, f, fl[0], fl[2:1], fl[4:3]);
        end
      end
    end
    @(posedge clk);
    @(posedge clk);
    driving_done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule